// File: doc/BRIEF.md
# Governed Predicate AND Unit with Condition Flags

This block performs the flag-setting, zeroing-governed AND of two lane predicates in a vector datapath. Each predicate holds one bit per byte lane of a vector. The maximum vector width in bits is a parameter, so a predicate has `MAX_VL_BITS/8` lanes. The block also holds a 16-entry predicate register file. A request names a destination, a governing mask and two source registers. For each lane, the block ANDs the two sources where the mask is active and writes zero where it is not. It then derives four condition flags from the result.

A runtime input gives the current vector length in lanes. Lanes at or above that length are treated as inactive, whatever the mask holds. The flags describe the result as seen through the active lanes:
- N takes the result bit of the lowest active lane.
- Z reports that no active lane is set.
- C takes the inverse of the result bit of the highest active lane.
- V is always cleared.

If a request names the same register for both sources, the block acts as a flag-setting predicate move under zeroing governance.

A load port fills registers and a registered read port returns them. These two ports exist so that the surrounding datapath, or a testbench, can set up and inspect state.

Top module: `pred_and_unit`

## Requirements
- R1: A predicate has one bit per byte lane: PL = MAX_VL_BITS/8 lanes. Lane i is bit i of a register, and lane 0 is the lowest-numbered lane.
- R2: A lane is active when its governing bit is 1 and its index is below the effective length. For each active lane, the result bit equals srca AND srcb.
- R3: Two kinds of lane are written as 0 in the destination: lanes whose governing bit is 0, and lanes at or beyond the effective length.
- R4: flag_n equals the result bit of the lowest-numbered active lane. It is 0 when no lane is active.
- R5: flag_z is 1 exactly when no active lane has its result bit set.
- R6: flag_c equals the inverse of the result bit of the highest-numbered active lane. With no active lane, the flags are N=0, Z=1, C=1.
- R7: flag_v is always 0.
- R8: Timing of a request:
  - At the clock edge that samples req_valid=1, the destination register is written and the flags are registered.
  - done_valid is 1 for the cycle that follows the request and 0 otherwise.
  - The flags hold their values when no request is made.
- R9: When req_srca equals req_srcb, the destination receives that source's bits on active lanes and 0 elsewhere.
- R10: When ld_valid=1 and req_valid=0, the load port writes ld_data to register ld_idx. In a cycle where req_valid=1, the request's write wins and the load is dropped.
- R11: rd_data returns the contents of register rd_idx one clock after rd_idx is presented.
- R12: After a synchronous reset, done_valid and all four flags are 0.
- R13: A vl_lanes value above PL is treated as PL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a governed AND |
| req_dst | input | 4 | Destination register index |
| req_gov | input | 4 | Governing mask register index |
| req_srca | input | 4 | First source register index |
| req_srcb | input | 4 | Second source register index |
| vl_lanes | input | LW | Current vector length in lanes, where LW = $clog2(PL+1) |
| ld_valid | input | 1 | Load a register |
| ld_idx | input | 4 | Register index for a load |
| ld_data | input | PL | Load data |
| rd_idx | input | 4 | Register index for a read |
| rd_data | output | PL | Registered read data |
| done_valid | output | 1 | A result was written on the previous edge |
| flag_n | output | 1 | Result bit of the first active lane |
| flag_z | output | 1 | No active result bit set |
| flag_c | output | 1 | Inverse of the result bit of the last active lane |
| flag_v | output | 1 | Always zero |

## Verification
A wrong lane-activity decision corrupts the destination register. It also moves which lanes count as first and last, so the error appears on the flags in the cycle right after the request. It appears in rd_data one cycle after that register is read. A stale write-port selection, where the load and the request collide, shows up as a wrong register value on the next read of either index. The bench compares every request's flags against a behavioural model on the following cycle, then reads back the destination. This puts every divergence at the ports within two clocks of the request.

// File: rtl/pred_and_pkg.sv
package pred_and_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic int lanes_of(input int vl_bits);
    return vl_bits / 8;
  endfunction

endpackage

// File: rtl/pred_regfile.sv
module pred_regfile #(
  parameter int PL    = 32,
  parameter int NREGS = 16,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [PL-1:0]   wr_data,
  input  logic [IDXW-1:0] ra_idx,
  input  logic [IDXW-1:0] rb_idx,
  input  logic [IDXW-1:0] rg_idx,
  input  logic [IDXW-1:0] rs_idx,
  output logic [PL-1:0]   ra_data,
  output logic [PL-1:0]   rb_data,
  output logic [PL-1:0]   rg_data,
  output logic [PL-1:0]   rs_data
);

  logic [PL-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign rg_data = mem[rg_idx];

  always_ff @(posedge clk) begin
    rs_data <= mem[rs_idx];
  end

endmodule

// File: rtl/pred_lane_and.sv
module pred_lane_and #(
  parameter int PL = 32,
  localparam int LW = $clog2(PL + 1)
) (
  input  logic [PL-1:0] gov,
  input  logic [PL-1:0] opa,
  input  logic [PL-1:0] opb,
  input  logic [LW-1:0] vl_lanes,
  output logic [PL-1:0] act,
  output logic [PL-1:0] res
);

  for (genvar i = 0; i < PL; i++) begin : g_lane
    logic in_len;
    assign in_len = (vl_lanes > LW'(i));
    assign act[i] = gov[i] & in_len;
    assign res[i] = act[i] & opa[i] & opb[i];
  end

endmodule

// File: rtl/pred_flag_scan.sv
module pred_flag_scan #(
  parameter int PL = 32
) (
  input  logic [PL-1:0] act,
  input  logic [PL-1:0] res,
  output logic          f_n,
  output logic          f_z,
  output logic          f_c
);

  logic [PL-1:0] first_oh;
  logic          last_bit;

  assign first_oh = act & (~act + PL'(1));

  always_comb begin
    last_bit = 1'b0;
    for (int i = 0; i < PL; i++) begin
      if (act[i]) last_bit = res[i];
    end
  end

  assign f_n = |(first_oh & res);
  assign f_z = ~|(res & act);
  assign f_c = ~last_bit;

  // R4: at most one lane may be picked as the first active lane
  always_comb begin
    a_r4_first_onehot: assert ($onehot0(first_oh));
  end

  // R6: with no active lane the flags read N=0, Z=1, C=1
  always_comb begin
    if (act == '0) a_r6_empty_flags: assert (!f_n && f_z && f_c);
  end

endmodule

// File: rtl/pred_and_unit.sv
module pred_and_unit #(
  parameter int MAX_VL_BITS = 256,
  parameter int NREGS       = 16,
  localparam int PL   = MAX_VL_BITS / 8,
  localparam int LW   = $clog2(PL + 1),
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [IDXW-1:0] req_dst,
  input  logic [IDXW-1:0] req_gov,
  input  logic [IDXW-1:0] req_srca,
  input  logic [IDXW-1:0] req_srcb,
  input  logic [LW-1:0]   vl_lanes,
  input  logic            ld_valid,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [PL-1:0]   ld_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [PL-1:0]   rd_data,
  output logic            done_valid,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_v
);
  import pred_and_pkg::*;

  logic [PL-1:0]   opa, opb, gov, act, res;
  logic [LW-1:0]   eff_len;
  logic            s_n, s_z, s_c;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [PL-1:0]   wr_data;
  nzcv_t           flags_q;

  // R13: clamp the runtime length to the lane count
  assign eff_len = (vl_lanes > LW'(PL)) ? LW'(PL) : vl_lanes;

  // R10: single write port, request has priority over load
  assign wr_en   = req_valid | ld_valid;
  assign wr_idx  = req_valid ? req_dst : ld_idx;
  assign wr_data = req_valid ? res : ld_data;

  pred_regfile #(.PL(PL), .NREGS(NREGS)) u_rf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_idx(req_srca), .rb_idx(req_srcb), .rg_idx(req_gov), .rs_idx(rd_idx),
    .ra_data(opa), .rb_data(opb), .rg_data(gov), .rs_data(rd_data)
  );

  pred_lane_and #(.PL(PL)) u_lanes (
    .gov(gov), .opa(opa), .opb(opb), .vl_lanes(eff_len), .act(act), .res(res)
  );

  pred_flag_scan #(.PL(PL)) u_scan (
    .act(act), .res(res), .f_n(s_n), .f_z(s_z), .f_c(s_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      flags_q    <= '0;
    end else begin
      done_valid <= req_valid;
      if (req_valid) flags_q <= '{n: s_n, z: s_z, c: s_c, v: 1'b0};
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R3: the lane stage never sets a bit outside the active set
  always_comb begin
    a_r3_inactive_zero: assert ((res & ~act) == '0);
  end

  a_r7_v_zero: assert property (@(posedge clk) disable iff (rst) !flag_v);
  a_r5_z_excludes_n: assert property (@(posedge clk) disable iff (rst) flag_z |-> !flag_n);
  a_r8_done_on_req: assert property (@(posedge clk) disable iff (rst) req_valid |=> done_valid);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !done_valid);
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable({flag_n, flag_z, flag_c}));

endmodule

// File: tb/pred_and_unit_tb_top.sv
module pred_and_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 32;
  localparam int LW = $clog2(PL + 1);

  logic clk = 0, rst = 1;
  logic req_valid = 0, ld_valid = 0;
  logic [3:0] req_dst = 0, req_gov = 0, req_srca = 0, req_srcb = 0, ld_idx = 0, rd_idx = 0;
  logic [LW-1:0] vl_lanes = 0;
  logic [PL-1:0] ld_data = 0, rd_data;
  logic done_valid, flag_n, flag_z, flag_c, flag_v;

  int checks = 0, fails = 0;
  logic [PL-1:0] model_rf [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_and_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst), .req_gov(req_gov),
    .req_srca(req_srca), .req_srcb(req_srcb), .vl_lanes(vl_lanes), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .done_valid(done_valid), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [PL-1:0] g, a, b, input int len,
                                 output logic [PL-1:0] r, output logic [3:0] f);
    int first = -1, last = -1;
    int eff = (len > PL) ? PL : len;
    r = '0;
    for (int e = 0; e < PL; e++) begin
      if (g[e] && e < eff) begin
        r[e] = a[e] & b[e];
        if (first < 0) first = e;
        last = e;
      end
    end
    f[3] = (first < 0) ? 1'b0 : r[first];
    f[2] = (r == '0);
    f[1] = (last < 0) ? 1'b1 : !r[last];
    f[0] = 1'b0;
  endfunction

  task automatic load(input int idx, input logic [PL-1:0] d);
    ld_valid = 1; ld_idx = 4'(idx); ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    model_rf[idx] = d;
  endtask

  task automatic read_chk(input int idx, input string req);
    rd_idx = 4'(idx);
    @(negedge clk);
    chk(req, 64'(rd_data), 64'(model_rf[idx]));
  endtask

  // issue one request; optionally collide with a load
  task automatic do_op(input int d, g, a, b, len, input bit coll, input int lidx,
                       input string req);
    logic [PL-1:0] r;
    logic [3:0] f;
    ref_op(model_rf[g], model_rf[a], model_rf[b], len, r, f);
    req_valid = 1; req_dst = 4'(d); req_gov = 4'(g); req_srca = 4'(a); req_srcb = 4'(b);
    vl_lanes = LW'(len);
    if (coll) begin ld_valid = 1; ld_idx = 4'(lidx); ld_data = ~model_rf[lidx]; end
    @(negedge clk);
    req_valid = 0; ld_valid = 0;
    model_rf[d] = r;
    chk({req, " R8 done"}, 64'(done_valid), 64'(1));
    chk({req, " R4 R5 R6 R7 flags"}, 64'({flag_n, flag_z, flag_c, flag_v}), 64'(f));
    read_chk(d, {req, " R2 R3 R11 dest"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0] fsave;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 reset", 64'({done_valid, flag_n, flag_z, flag_c, flag_v}), 64'(0));
    // R1 R10: load every register, read back full lane width
    for (int i = 0; i < 16; i++) load(i, $urandom());
    load(15, '1);
    for (int i = 0; i < 16; i++) read_chk(i, "R1 R10 load");
    // R6 all-inactive mask
    load(0, '0);
    do_op(1, 0, 2, 3, PL, 0, 0, "R6 empty gov");
    // R6 zero length
    do_op(1, 15, 2, 3, 0, 0, 0, "R6 zero len");
    // single active lanes: result 1 and 0
    load(4, 32'h0000_0100); load(5, '1); load(6, '0);
    do_op(7, 4, 5, 5, PL, 0, 0, "R4 R6 single set");
    do_op(7, 4, 5, 6, PL, 0, 0, "R5 R6 single clear");
    // R13 length above PL, R3 length cut
    do_op(8, 15, 5, 5, PL + 20, 0, 0, "R13 over length");
    do_op(8, 15, 5, 5, 5, 0, 0, "R3 short length");
    // R9 move: same sources
    do_op(9, 2, 3, 3, PL, 0, 0, "R9 move");
    // R10 collision: same index, request wins
    do_op(10, 2, 3, 11, PL, 1, 10, "R10 same idx");
    // R10 collision: different index, load dropped
    do_op(11, 2, 3, 12, PL, 1, 13, "R10 other idx");
    read_chk(13, "R10 dropped load");
    // R8 idle hold
    fsave = {flag_n, flag_z, flag_c, flag_v};
    @(negedge clk);
    chk("R8 idle done", 64'(done_valid), 64'(0));
    chk("R8 idle hold", 64'({flag_n, flag_z, flag_c, flag_v}), 64'(fsave));
    // random sweep
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) load(int'($urandom_range(0, 15)), $urandom());
      do_op(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, PL + 3)), 0, 0, "R2 R4 R5 R6 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule